// File: doc/BRIEF.md
# Burst Offset Sequencer

This block produces the low address bits of a short memory burst. A load strobe captures a start offset and the upper address bits. Each later advance strobe steps the offset to the next beat of the burst. With the default width of two offset bits, a single presented address yields four beats. Past the last beat the sequence wraps to the start offset and goes on counting for as long as advances keep coming.

Two beat orders exist, selected by a static mode input. In linear order the offset counts up modulo the burst length from the start offset. In interleaved order the offset is the start offset XORed with the beat number. A stop strobe, raised when the memory is deselected, ends the burst in progress. An active-high stall input freezes the whole block for that clock edge. The upper address bits are held unchanged from the load for the whole burst.

Every output is registered. A command takes effect at the clock edge where it is sampled, and the outputs show the result one cycle later.

Top module: `burst_offset_seq`

## Requirements
- R1: A synchronous reset clears the outputs: `busy` = 0, `ofs` = 0, `upper` = 0.
- R2: A load (`load` = 1, `stop` = 0, `stall` = 0) sets `ofs` to `start_ofs`, `upper` to `start_upper` and `busy` to 1 in the next cycle, in either order.
- R3: With `order_ilv` = 0 (linear), beat n of a burst shows `ofs` = (`start_ofs` + n) mod 2^OFS_W. For example, a start of 1 gives 1, 2, 3, 0.
- R4: With `order_ilv` = 1 (interleaved), beat n shows `ofs` = `start_ofs` XOR n. For example, a start of 1 gives 1, 0, 3, 2.
- R5: After the last beat the sequence wraps to the start offset and keeps counting in the same order while `adv` stays asserted.
- R6: When `stall` = 1, all outputs keep their values for that edge, whatever the other inputs are.
- R7: A stop (`stop` = 1, `stall` = 0) clears `busy` and leaves `ofs` and `upper` unchanged. Stop takes priority over a load in the same cycle.
- R8: An `adv` pulse while `busy` = 0 is ignored: `ofs`, `upper` and `busy` stay unchanged.
- R9: A load while a burst is active restarts the burst from the new start offset. Load takes priority over `adv` in the same cycle.
- R10: `upper` does not change on an advance. It changes only on a load or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freezes all state for this edge when high |
| order_ilv | input | 1 | Static beat order: 1 interleaved, 0 linear |
| load | input | 1 | Load strobe for a new start address |
| start_ofs | input | OFS_W | Start offset captured on load |
| start_upper | input | UP_W | Upper address bits captured on load |
| adv | input | 1 | Advance strobe, steps to the next beat |
| stop | input | 1 | Ends the burst (deselect) |
| ofs | output | OFS_W | Current burst offset |
| upper | output | UP_W | Upper address bits held from the load |
| busy | output | 1 | A burst is active |

## Verification
The assertions check on every cycle the rules that relate one edge to the next:
- reset clearing,
- stall freezing every output,
- stop dropping `busy`,
- a load landing the start values,
- ignored advances when idle,
- `upper` held across advances,
- the plus-one step of linear order,
- the fact that an interleaved step always changes the offset.

The exact interleaved sequence values, the wrap back to the start after the last beat, and the priority between load and advance in the same cycle are shown by the bench scenarios. The bench compares its own burst model against the outputs, over directed bursts and long random command streams in both orders.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Command resolved for one clock edge, in priority order
  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_STOP = 2'd1,
    CMD_LOAD = 2'd2,
    CMD_STEP = 2'd3
  } seq_cmd_e;
endpackage

// File: rtl/burst_seq_decode.sv
module burst_seq_decode
  import burst_seq_pkg::*;
(
  input  logic     stall,
  input  logic     stop,
  input  logic     load,
  input  logic     adv,
  input  logic     active,
  output seq_cmd_e cmd
);
  // stall beats stop, stop beats load, load beats adv; adv needs an active burst
  always_comb begin
    cmd = CMD_HOLD;
    if (!stall) begin
      if (stop)                cmd = CMD_STOP;
      else if (load)           cmd = CMD_LOAD;
      else if (adv && active)  cmd = CMD_STEP;
    end
  end
endmodule

// File: rtl/burst_seq_beat.sv
module burst_seq_beat
  import burst_seq_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  seq_cmd_e         cmd,
  output logic [OFS_W-1:0] beat_nxt
);
  logic [OFS_W-1:0] beat_q;

  always_comb begin
    unique case (cmd)
      CMD_LOAD: beat_nxt = '0;
      CMD_STEP: beat_nxt = beat_q + 1'b1;  // natural wrap at 2^OFS_W
      default:  beat_nxt = beat_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_nxt;
  end
endmodule

// File: rtl/burst_seq_order.sv
module burst_seq_order #(
  parameter int OFS_W = 2
) (
  input  logic             ilv,
  input  logic [OFS_W-1:0] base,
  input  logic [OFS_W-1:0] beat,
  output logic [OFS_W-1:0] ofs
);
  logic [OFS_W-1:0] lin_ofs;
  logic [OFS_W-1:0] ilv_ofs;

  assign lin_ofs = base + beat;

  // interleaved order is a plain bitwise XOR, built bit by bit
  for (genvar b = 0; b < OFS_W; b++) begin : g_ilv_bit
    assign ilv_ofs[b] = base[b] ^ beat[b];
  end

  assign ofs = ilv ? ilv_ofs : lin_ofs;
endmodule

// File: rtl/burst_offset_seq.sv
module burst_offset_seq
  import burst_seq_pkg::*;
#(
  parameter int OFS_W = 2,
  parameter int UP_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall,
  input  logic             order_ilv,
  input  logic             load,
  input  logic [OFS_W-1:0] start_ofs,
  input  logic [UP_W-1:0]  start_upper,
  input  logic             adv,
  input  logic             stop,
  output logic [OFS_W-1:0] ofs,
  output logic [UP_W-1:0]  upper,
  output logic             busy
);
  seq_cmd_e         cmd;
  logic [OFS_W-1:0] beat_nxt;
  logic [OFS_W-1:0] base_q;
  logic [OFS_W-1:0] base_nxt;
  logic [OFS_W-1:0] ofs_nxt;

  burst_seq_decode u_decode (
    .stall  (stall),
    .stop   (stop),
    .load   (load),
    .adv    (adv),
    .active (busy),
    .cmd    (cmd)
  );

  burst_seq_beat #(.OFS_W(OFS_W)) u_beat (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .beat_nxt (beat_nxt)
  );

  assign base_nxt = (cmd == CMD_LOAD) ? start_ofs : base_q;

  burst_seq_order #(.OFS_W(OFS_W)) u_order (
    .ilv  (order_ilv),
    .base (base_nxt),
    .beat (beat_nxt),
    .ofs  (ofs_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      upper  <= '0;
      ofs    <= '0;
      busy   <= 1'b0;
    end else begin
      unique case (cmd)
        CMD_LOAD: begin
          base_q <= start_ofs;
          upper  <= start_upper;
          ofs    <= ofs_nxt;
          busy   <= 1'b1;
        end
        CMD_STEP: ofs  <= ofs_nxt;
        CMD_STOP: busy <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/burst_offset_seq_chk.sv
module burst_offset_seq_chk #(
  parameter int OFS_W = 2,
  parameter int UP_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             stall,
  input logic             order_ilv,
  input logic             load,
  input logic [OFS_W-1:0] start_ofs,
  input logic [UP_W-1:0]  start_upper,
  input logic             adv,
  input logic             stop,
  input logic [OFS_W-1:0] ofs,
  input logic [UP_W-1:0]  upper,
  input logic             busy
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: one cycle after reset the outputs are clear
  always @(posedge clk) begin
    if (rst_q === 1'b1)
      a_r1_reset_clear: assert (busy == 1'b0 && ofs == '0 && upper == '0);
  end

  a_r6_stall_freeze: assert property (@(posedge clk) disable iff (rst)
    (stall && !rst_q) |=> ($stable(ofs) && $stable(upper) && $stable(busy)));

  a_r7_stop_idle: assert property (@(posedge clk) disable iff (rst)
    (stop && !stall) |=> !busy);

  a_r7_stop_keeps_ofs: assert property (@(posedge clk) disable iff (rst)
    (stop && !stall && !rst_q) |=> ($stable(ofs) && $stable(upper)));

  a_r2_load_lands: assert property (@(posedge clk) disable iff (rst)
    (load && !stop && !stall) |=> (busy && ofs == $past(start_ofs)
                                   && upper == $past(start_upper)));

  a_r8_idle_adv_ignored: assert property (@(posedge clk) disable iff (rst)
    (adv && !busy && !load && !stop && !stall && !rst_q)
      |=> ($stable(ofs) && !busy));

  a_r10_upper_held: assert property (@(posedge clk) disable iff (rst)
    (!load && !rst_q) |=> $stable(upper));

  a_r3_linear_step: assert property (@(posedge clk) disable iff (rst)
    (adv && busy && !load && !stop && !stall && !order_ilv && !rst_q)
      |=> (ofs == $past(ofs) + 1'b1));

  a_r4_ilv_step_moves: assert property (@(posedge clk) disable iff (rst)
    (adv && busy && !load && !stop && !stall && order_ilv && !rst_q)
      |=> ($countones(ofs ^ $past(ofs)) >= 1));
endmodule

bind burst_offset_seq burst_offset_seq_chk #(.OFS_W(OFS_W), .UP_W(UP_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .stall       (stall),
  .order_ilv   (order_ilv),
  .load        (load),
  .start_ofs   (start_ofs),
  .start_upper (start_upper),
  .adv         (adv),
  .stop        (stop),
  .ofs         (ofs),
  .upper       (upper),
  .busy        (busy)
);

// File: tb/test_burst_offset_seq.sv
module test_burst_offset_seq;
  localparam int OFS_W = 2;
  localparam int UP_W  = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             stall = 1'b0, order_ilv = 1'b0, load = 1'b0, adv = 1'b0, stop = 1'b0;
  logic [OFS_W-1:0] start_ofs = '0;
  logic [UP_W-1:0]  start_upper = '0;
  logic [OFS_W-1:0] ofs;
  logic [UP_W-1:0]  upper;
  logic             busy;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model state
  logic [OFS_W-1:0] m_base, m_beat, m_ofs;
  logic [UP_W-1:0]  m_up;
  logic             m_act;

  always #4 clk = ~clk;

  burst_offset_seq #(.OFS_W(OFS_W), .UP_W(UP_W)) i_burst_offset_seq (
    .clk(clk), .rst(rst), .stall(stall), .order_ilv(order_ilv), .load(load),
    .start_ofs(start_ofs), .start_upper(start_upper), .adv(adv), .stop(stop),
    .ofs(ofs), .upper(upper), .busy(busy)
  );

  function automatic logic [OFS_W-1:0] exp_ofs(logic [OFS_W-1:0] b, logic [OFS_W-1:0] n,
                                               logic ilv);
    return ilv ? (b ^ n) : (b + n);
  endfunction

  task automatic check(string tag);
    total++;
    if (ofs !== m_ofs || upper !== m_up || busy !== m_act) begin
      bad++;
      $display("FAIL %s: ofs=%0d upper=%h busy=%0d expected ofs=%0d upper=%h busy=%0d",
               tag, ofs, upper, busy, m_ofs, m_up, m_act);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; stall = 0; load = 0; adv = 0; stop = 0;
    @(posedge clk); @(posedge clk); #1;
    m_base = '0; m_beat = '0; m_ofs = '0; m_up = '0; m_act = 1'b0;
    check("R1 reset");
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(logic s, logic t, logic l, logic a,
                      logic [OFS_W-1:0] so, logic [UP_W-1:0] su, string tag);
    @(negedge clk);
    stall = s; stop = t; load = l; adv = a; start_ofs = so; start_upper = su;
    @(posedge clk); #1;
    if (!s) begin
      if (t) m_act = 1'b0;
      else if (l) begin
        m_base = so; m_up = su; m_beat = '0; m_act = 1'b1; m_ofs = so;
      end else if (a && m_act) begin
        m_beat = m_beat + 1'b1;
        m_ofs  = exp_ofs(m_base, m_beat, order_ilv);
      end
    end
    check(tag);
  endtask

  task automatic rand_phase(int n);
    for (int i = 0; i < n; i++) begin
      step(($urandom % 8) == 0, ($urandom % 16) == 0, ($urandom % 4) == 0,
           ($urandom % 2) == 0, OFS_W'($urandom), UP_W'($urandom), "R3 R4 R5 random");
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd17));
    order_ilv = 1'b0;
    do_reset();
    step(0, 0, 0, 1, 2'd0, 16'h0, "R8 idle adv ignored");
    step(0, 0, 1, 0, 2'd1, 16'h1234, "R2 load linear");
    step(0, 0, 0, 1, 2'd3, 16'hFFFF, "R3 beat1 R10 upper held");
    step(0, 0, 0, 1, 2'd0, 16'h0, "R3 beat2");
    step(0, 0, 0, 1, 2'd0, 16'h0, "R3 beat3");
    step(0, 0, 0, 1, 2'd0, 16'h0, "R5 wrap to start");
    step(0, 0, 0, 1, 2'd0, 16'h0, "R5 keeps counting");
    step(1, 0, 1, 1, 2'd3, 16'hBEEF, "R6 stall freeze");
    step(0, 0, 1, 1, 2'd3, 16'hBEEF, "R9 reload over adv");
    step(0, 0, 0, 1, 2'd0, 16'h0, "R9 restart linear");
    step(0, 1, 1, 0, 2'd2, 16'h5555, "R7 stop over load");
    step(0, 0, 0, 1, 2'd0, 16'h0, "R8 adv after stop");
    do_reset();
    order_ilv = 1'b1;
    step(0, 0, 1, 0, 2'd1, 16'hA5A5, "R2 load ilv");
    step(0, 0, 0, 1, 2'd0, 16'h0, "R4 beat1");
    step(0, 0, 0, 1, 2'd0, 16'h0, "R4 beat2");
    step(0, 0, 0, 1, 2'd0, 16'h0, "R4 beat3");
    step(0, 0, 0, 1, 2'd0, 16'h0, "R5 ilv wrap");
    step(0, 0, 1, 0, 2'd2, 16'h0F0F, "R2 load ilv start 2");
    step(0, 0, 0, 1, 2'd0, 16'h0, "R4 start2 beat1");
    rand_phase(1500);
    do_reset();
    order_ilv = 1'b0;
    rand_phase(1500);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule